// File: doc/BRIEF.md
# Multi-Pattern Serial Test Generator

This block produces one 20-bit parallel word per clock for a serializer that sends bit 0 of each word first. A three-bit mode input selects the content: one of four pseudo-random bit sequences (PRBS-7, PRBS-15, PRBS-23, PRBS-31), a square wave with a 20 UI period, a square wave with a 2 UI period, a repeating four-symbol link compliance pattern, or an all-zero idle word. Each PRBS engine advances a full word of sequence bits per clock.

Two controls act on the output word. A single-cycle error request flips one bit of the next word, so a far-end checker sees exactly one bit error. A polarity-invert level complements every output bit. The output is registered. Every engine restarts from a fixed seed on reset and on every change of mode.

Top module: `tx_testpat_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `dout_o` is all zeros after that edge.
- R2: Mode 0 emits PRBS-7. The serial stream b[n] = b[n-6] xor b[n-7] starts from a history of all ones, so b[0] = 0. Word k holds b[20k] in bit 0 up to b[20k+19] in bit 19. Word 127 equals word 0.
- R3: Mode 1 emits PRBS-15 in the same way, with b[n] = b[n-14] xor b[n-15]. Word 32767 equals word 0.
- R4: Mode 2 emits PRBS-23 in the same way, with b[n] = b[n-18] xor b[n-23].
- R5: Mode 3 emits PRBS-31 in the same way, with b[n] = b[n-28] xor b[n-31].
- R6: Mode 4 emits 20'h003FF on every word: ten ones first, then ten zeros.
- R7: Mode 5 emits 20'h55555 on every word: ones and zeros alternate, and a one is sent first.
- R8: Mode 6 sends the 10-bit symbols 0011111010, 1010101010, 1100000101 and 0101010101 in that order, leftmost character first. The words are 20'h5557C and 20'hAAA83, which alternate starting with 20'h5557C.
- R9: A change of mode, sampled at an edge, restarts the selected pattern from its first word (PRBS seed all ones, compliance word 20'h5557C).
- R10: `err_inj_i` high at an edge flips bit 0 of the word produced at that edge only. The pattern sequence continues unchanged afterwards.
- R11: `inv_i` high at an edge complements all 20 bits of the word produced at that edge. Error injection is applied before inversion.
- R12: Mode 7 emits all zeros, which inversion and error injection may still modify.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Pattern select (0-3 PRBS-7/15/23/31, 4 long square, 5 short square, 6 compliance, 7 idle) |
| err_inj_i | input | 1 | Single-cycle request to corrupt bit 0 of the next word |
| inv_i | input | 1 | Complement every output bit while high |
| dout_o | output | 20 | Registered output word, bit 0 sent first |

## Verification
The assertions assume that `mode_i`, `err_inj_i` and `inv_i` are stable around the rising edge, and that `err_inj_i` is a single-cycle pulse. They check the fixed patterns against constant words and use `$past` of the controls to account for inversion and injection. The stimulus changes all inputs only on the falling edge and raises the error request for one cycle at a time. The PRBS content is compared word by word against a serial model of each recurrence, and both shorter sequences are run through a complete period.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int WORD_W   = 20;
    localparam int SYM_W    = 10;
    localparam int NUM_SYM  = 4;
    localparam int NUM_PRBS = 4;
    localparam int MODE_W   = 3;

    typedef enum logic [MODE_W-1:0] {
        PAT_PRBS7    = 3'd0,
        PAT_PRBS15   = 3'd1,
        PAT_PRBS23   = 3'd2,
        PAT_PRBS31   = 3'd3,
        PAT_SQ_LONG  = 3'd4,
        PAT_SQ_SHORT = 3'd5,
        PAT_CMPL     = 3'd6,
        PAT_IDLE     = 3'd7
    } pat_mode_e;

    // Word handed to the output stage together with its modifiers.
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              err;
        logic              inv;
    } out_req_t;

    // Register length of each PRBS engine.
    function automatic int prbs_len(input int k);
        case (k)
            0:       return 7;
            1:       return 15;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    // Inner feedback tap of each PRBS engine.
    function automatic int prbs_tap(input int k);
        case (k)
            0:       return 6;
            1:       return 14;
            2:       return 18;
            default: return 28;
        endcase
    endfunction

    // Compliance symbols written as sent, leftmost character first.
    function automatic logic [SYM_W-1:0] cmpl_symbol(input int idx);
        case (idx % NUM_SYM)
            0:       return 10'b0011111010;
            1:       return 10'b1010101010;
            2:       return 10'b1100000101;
            default: return 10'b0101010101;
        endcase
    endfunction

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
    parameter int LEN = 7,
    parameter int TAP = 6,
    parameter int W   = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] word_o
);

    // hist[k] holds the bit sent k+1 positions before the next one.
    logic [LEN-1:0] hist_q;
    logic [LEN-1:0] hist_cur;
    logic [LEN-1:0] hist_nxt;

    always_comb begin
        logic fb;
        hist_cur = restart ? {LEN{1'b1}} : hist_q;
        hist_nxt = hist_cur;
        word_o   = '0;
        for (int i = 0; i < W; i++) begin
            fb        = hist_nxt[LEN-1] ^ hist_nxt[TAP-1];
            word_o[i] = fb;
            hist_nxt  = {hist_nxt[LEN-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= {LEN{1'b1}};
        end else begin
            hist_q <= hist_nxt;
        end
    end

endmodule

// File: rtl/tpg_fixed.sv
module tpg_fixed
    import tpg_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] long_o,
    output logic [W-1:0] short_o,
    output logic [W-1:0] cmpl_o
);

    localparam int HALF      = W / 2;
    localparam int SYM_PER_W = W / SYM_W;

    logic phase_q;
    logic phase_cur;

    assign phase_cur = restart ? 1'b0 : phase_q;

    always_comb begin
        logic [SYM_W-1:0] sym;
        int               sidx;
        long_o  = '0;
        short_o = '0;
        cmpl_o  = '0;
        for (int i = 0; i < W; i++) begin
            long_o[i]  = (i < HALF);
            short_o[i] = ((i % 2) == 0);
            sidx       = int'(phase_cur) * SYM_PER_W + i / SYM_W;
            sym        = cmpl_symbol(sidx);
            cmpl_o[i]  = sym[SYM_W-1-(i % SYM_W)];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_cur;
        end
    end

endmodule

// File: rtl/tpg_out.sv
module tpg_out
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  out_req_t          req_i,
    output logic [WORD_W-1:0] dout_o
);

    logic [WORD_W-1:0] err_mask;

    assign err_mask = {{(WORD_W-1){1'b0}}, req_i.err};

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_o <= '0;
        end else begin
            dout_o <= (req_i.data ^ err_mask) ^ {WORD_W{req_i.inv}};
        end
    end

endmodule

// File: rtl/tx_testpat_gen.sv
module tx_testpat_gen
    import tpg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [tpg_pkg::MODE_W-1:0] mode_i,
    input  logic                       err_inj_i,
    input  logic                       inv_i,
    output logic [tpg_pkg::WORD_W-1:0] dout_o
);

    pat_mode_e         mode_q;
    pat_mode_e         mode_cur;
    logic              restart;
    logic [WORD_W-1:0] prbs_word [NUM_PRBS];
    logic [WORD_W-1:0] long_word;
    logic [WORD_W-1:0] short_word;
    logic [WORD_W-1:0] cmpl_word;
    out_req_t          req;

    assign mode_cur = pat_mode_e'(mode_i);
    assign restart  = (mode_cur != mode_q);

    always_ff @(posedge clk) begin
        mode_q <= mode_cur;
    end

    for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
        tpg_lfsr #(
            .LEN (prbs_len(g)),
            .TAP (prbs_tap(g)),
            .W   (WORD_W)
        ) u_lfsr (
            .clk     (clk),
            .rst     (rst),
            .restart (restart),
            .word_o  (prbs_word[g])
        );
    end

    tpg_fixed #(
        .W (WORD_W)
    ) u_fixed (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .long_o  (long_word),
        .short_o (short_word),
        .cmpl_o  (cmpl_word)
    );

    always_comb begin
        req.err = err_inj_i;
        req.inv = inv_i;
        unique case (mode_cur)
            PAT_PRBS7:    req.data = prbs_word[0];
            PAT_PRBS15:   req.data = prbs_word[1];
            PAT_PRBS23:   req.data = prbs_word[2];
            PAT_PRBS31:   req.data = prbs_word[3];
            PAT_SQ_LONG:  req.data = long_word;
            PAT_SQ_SHORT: req.data = short_word;
            PAT_CMPL:     req.data = cmpl_word;
            default:      req.data = '0;
        endcase
    end

    tpg_out u_out (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .dout_o (dout_o)
    );

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  mode_i,
    input logic        err_inj_i,
    input logic        inv_i,
    input logic [19:0] dout_o
);

    localparam logic [19:0] CW_A = 20'h5557C;
    localparam logic [19:0] CW_B = 20'hAAA83;

    logic [19:0] mod_mask;
    assign mod_mask = {20{inv_i}} ^ {19'b0, err_inj_i};

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (dout_o == 20'h0)); // R1

    AST_LONG_SQUARE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd4) |=> (dout_o == (20'h003FF ^ $past(mod_mask)))); // R6 R10 R11

    AST_SHORT_SQUARE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd5) |=> (dout_o == (20'h55555 ^ $past(mod_mask)))); // R7 R10 R11

    AST_CMPL_WORDS: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd6 && !err_inj_i && !inv_i) |=> (dout_o == CW_A || dout_o == CW_B)); // R8

    AST_CMPL_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd6 && mode_i != $past(mode_i) && !err_inj_i && !inv_i) |=> (dout_o == CW_A)); // R9

    AST_CMPL_ALTERNATE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd6 && $past(mode_i) == 3'd6 && !err_inj_i && !inv_i
         && !$past(err_inj_i) && !$past(inv_i) && !$past(rst))
        |=> (dout_o != $past(dout_o))); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'd7) |=> (dout_o == $past(mod_mask))); // R12

endmodule

bind tx_testpat_gen tpg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .err_inj_i (err_inj_i),
    .inv_i     (inv_i),
    .dout_o    (dout_o)
);

// File: tb/tx_testpat_gen_tb.sv
module tx_testpat_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'd0;
    logic        err = 1'b0;
    logic        inv = 1'b0;
    logic [19:0] dout;

    int checks   = 0;
    int failures = 0;

    // serial model state
    logic [30:0] mh;
    bit          mph;
    int          prev_m = -1;
    bit          restart_pend = 1'b1;
    logic [19:0] sy [4] = '{10'b0011111010, 10'b1010101010, 10'b1100000101, 10'b0101010101};

    tx_testpat_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .err_inj_i (err),
        .inv_i     (inv),
        .dout_o    (dout)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input int m);
        case (m)
            0: return "R2 prbs7";
            1: return "R3 prbs15";
            2: return "R4 prbs23";
            3: return "R5 prbs31";
            4: return "R6 long square";
            5: return "R7 short square";
            6: return "R8 compliance";
            default: return "R12 idle";
        endcase
    endfunction

    // One cycle: drive at a falling edge, sample at the next falling edge.
    task automatic cyc(input int m, input bit e, input bit v, input string req);
        logic [19:0] w;
        logic [19:0] exp;
        int len;
        int tap;
        logic nb;
        mode = m[2:0];
        err  = e;
        inv  = v;
        if (restart_pend || m != prev_m) begin
            mh  = '1;
            mph = 1'b0;
        end
        restart_pend = 1'b0;
        prev_m = m;
        w = '0;
        if (m < 4) begin
            len = (m == 0) ? 7 : (m == 1) ? 15 : (m == 2) ? 23 : 31;
            tap = (m == 0) ? 6 : (m == 1) ? 14 : (m == 2) ? 18 : 28;
            for (int i = 0; i < 20; i++) begin
                nb   = mh[len-1] ^ mh[tap-1];
                w[i] = nb;
                mh   = {mh[29:0], nb};
            end
        end else if (m == 4) begin
            for (int i = 0; i < 20; i++) w[i] = (i < 10);
        end else if (m == 5) begin
            for (int i = 0; i < 20; i++) w[i] = ((i % 2) == 0);
        end else if (m == 6) begin
            for (int i = 0; i < 20; i++) w[i] = sy[int'(mph) * 2 + i / 10][9 - (i % 10)];
            mph = ~mph;
        end
        exp = w ^ {20{v}};
        exp[0] = exp[0] ^ e;
        @(negedge clk);
        check(dout == exp, req, dout, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        err = 1'b0;
        inv = 1'b0;
        @(negedge clk);
        check(dout == 20'h0, "R1 reset", dout, 20'h0);
        @(negedge clk);
        check(dout == 20'h0, "R1 reset hold", dout, 20'h0);
        rst = 1'b0;
        restart_pend = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [19:0] first7;
        logic [19:0] first15;
        @(negedge clk);
        do_reset();

        // R2: PRBS-7 through one full period plus a margin
        cyc(0, 0, 0, "R2 prbs7");
        first7 = dout;
        for (int k = 1; k < 127; k++) cyc(0, 0, 0, "R2 prbs7");
        cyc(0, 0, 0, "R2 prbs7 wrap");
        check(dout == first7, "R2 period 127 words", dout, first7);
        for (int k = 0; k < 20; k++) cyc(0, 0, 0, "R2 prbs7");

        // R3: PRBS-15 full period, R9 restart via the mode change
        cyc(1, 0, 0, "R3 R9 prbs15 first");
        first15 = dout;
        for (int k = 1; k < 32767; k++) cyc(1, 0, 0, "R3 prbs15");
        cyc(1, 0, 0, "R3 prbs15 wrap");
        check(dout == first15, "R3 period 32767 words", dout, first15);

        for (int k = 0; k < 400; k++) cyc(2, 0, 0, "R4 prbs23");
        for (int k = 0; k < 400; k++) cyc(3, 0, 0, "R5 prbs31");

        for (int m = 4; m < 8; m++)
            for (int k = 0; k < 24; k++) cyc(m, 0, 0, tag_of(m));

        // R9: returning to PRBS-7 restarts at its first word
        cyc(0, 0, 0, "R9 restart prbs7");
        check(dout == first7, "R9 prbs7 restart word", dout, first7);
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, "R2 prbs7");
        // R9: compliance phase restarts after a one-cycle excursion
        cyc(6, 0, 0, "R9 cmpl start");
        check(dout == 20'h5557C, "R8 first compliance word", dout, 20'h5557C);
        cyc(6, 0, 0, "R8 cmpl");
        check(dout == 20'hAAA83, "R8 second compliance word", dout, 20'hAAA83);
        cyc(6, 0, 0, "R8 cmpl");
        cyc(5, 0, 0, "R7 short");
        cyc(6, 0, 0, "R9 cmpl restart");
        check(dout == 20'h5557C, "R9 compliance restart word", dout, 20'h5557C);

        // R10: single-word error injection in every mode
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 6; k++) cyc(m, 0, 0, tag_of(m));
            cyc(m, 1, 0, "R10 inject");
            for (int k = 0; k < 6; k++) cyc(m, 0, 0, "R10 after inject");
        end

        // R11: inversion in every mode, alone and combined with injection
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 8; k++) cyc(m, 0, 1, "R11 invert");
            cyc(m, 1, 1, "R10 R11 inject+invert");
            for (int k = 0; k < 4; k++) cyc(m, 0, 0, "R11 invert released");
        end

        // R1: reset in the middle of a run, then restart from the seed
        for (int k = 0; k < 10; k++) cyc(3, 0, 0, "R5 prbs31");
        do_reset();
        for (int k = 0; k < 30; k++) cyc(3, 0, 0, "R1 R5 prbs31 after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule